// File: doc/BRIEF.md
# Stack Window Guard for Load/Store Addresses

This block sits beside the address stage of a processor pipeline. For every load or store it forms the effective address from its operands and, when general register 1 (the stack pointer) is one of the address sources, tests that address against a programmable window bounded by a low and a high limit. An address outside the window is a stack-bounds fault. The block then raises an exception pulse and supplies the values for the exception address and exception status registers.

Software sets the two limits with special-register move instructions that carry a special-register number. Reset leaves the window fully open, so nothing faults until software narrows it. Instruction decode, the memory access itself and the vectoring to the handler belong to neighbouring blocks.

Top module: `stack_guard`

## Requirements
- R1: `eff_addr` is combinationally `op_a + op_b` when `imm_form` is 0, and `op_a + imm` when `imm_form` is 1, modulo 2^32.
- R2: An access with `ls_valid` high and `ra_idx` equal to 1 is checked in either form.
- R3: When `imm_form` is 0, an access with `rb_idx` equal to 1 is also checked. When `imm_form` is 1, `rb_idx` has no effect and only `ra_idx` can enable the check.
- R4: A checked access faults when `eff_addr` is unsigned-below the low limit or unsigned-above the high limit. Addresses equal to either limit do not fault.
- R5: A faulting access drives `exc_pulse` high for exactly the following cycle, and `exc_addr` takes the faulting effective address in that same cycle.
- R6: On a fault, `exc_status` becomes 32'h0000_0007: cause code 7 (the privileged-instruction code) in bits [4:0], with every other bit zero.
- R7: Special-register number 14'h800 selects the low limit and 14'h802 the high limit. A write with `sr_wr` high stores `sr_wdata` and takes effect from the next cycle. `sr_rdata` returns the selected stored limit in the same cycle, and 0 for any other number.
- R8: After reset the low limit is 0, the high limit is 32'hFFFF_FFFF, `exc_pulse` is 0, and `exc_addr` and `exc_status` are 0.
- R9: While `ls_valid` is low, `exc_pulse` stays low in the next cycle whatever the operands and indices are.
- R10: `exc_addr` and `exc_status` keep their values in every cycle that does not follow a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ls_valid | input | 1 | A load or store is in the address stage this cycle |
| ra_idx | input | 5 | Register index of operand A |
| rb_idx | input | 5 | Register index of operand B |
| op_a | input | 32 | Value of operand A |
| op_b | input | 32 | Value of operand B |
| imm | input | 32 | Immediate offset, sign extension done upstream |
| imm_form | input | 1 | 1 = immediate form, 0 = register-register form |
| sr_num | input | 14 | Special-register number for a limit move |
| sr_wr | input | 1 | Write the selected limit this cycle |
| sr_wdata | input | 32 | Value to write into the selected limit |
| sr_rdata | output | 32 | Stored value of the selected limit |
| eff_addr | output | 32 | Effective address, combinational |
| exc_pulse | output | 1 | One-cycle stack-bounds exception |
| exc_addr | output | 32 | Value for the exception address register |
| exc_status | output | 32 | Value for the exception status register |

## Verification
`eff_addr` and `sr_rdata` are due in the cycle their inputs are applied. The bench drives inputs just after a falling edge and samples these two outputs one time unit later, before the next rising edge. `exc_pulse`, `exc_addr` and `exc_status` are due one rising edge after the access that causes them, so the bench checks them at the following falling edge against values it predicted from the previous cycle's inputs. A limit write changes the bench's model only after that cycle's prediction is made, which matches a write that takes effect on the next cycle.

// File: rtl/sg_pkg.sv
package sg_pkg;
    localparam int unsigned SG_XLEN   = 32;
    localparam int unsigned SG_IDX_W  = 5;
    localparam int unsigned SG_SRN_W  = 14;
    localparam int unsigned SG_CAUSE_W = 5;

    // Cause code shared with the privileged-instruction fault.
    localparam logic [SG_CAUSE_W-1:0] SG_CAUSE_STACK = 5'd7;

    typedef struct packed {
        logic [SG_XLEN-1:0] lo;
        logic [SG_XLEN-1:0] hi;
    } sg_limits_t;

    typedef struct packed {
        logic               exc;
        logic [SG_XLEN-1:0] ear;
        logic [SG_XLEN-1:0] esr;
    } sg_fault_t;
endpackage

// File: rtl/sg_limit_regs.sv
module sg_limit_regs
    import sg_pkg::*;
#(
    parameter int unsigned           XLEN   = SG_XLEN,
    parameter int unsigned           SRN_W  = SG_SRN_W,
    parameter logic [SRN_W-1:0]      LO_NUM = 14'h800,
    parameter logic [SRN_W-1:0]      HI_NUM = 14'h802
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRN_W-1:0] sr_num,
    input  logic             sr_wr,
    input  logic [XLEN-1:0]  sr_wdata,
    output logic [XLEN-1:0]  sr_rdata,
    output logic [XLEN-1:0]  lim_lo,
    output logic [XLEN-1:0]  lim_hi
);
    logic            sel_lo, sel_hi;
    logic [XLEN-1:0] lo_d, lo_q, hi_d, hi_q;

    assign sel_lo = (sr_num == LO_NUM);
    assign sel_hi = (sr_num == HI_NUM);

    always_comb begin
        lo_d = lo_q;
        hi_d = hi_q;
        if (sr_wr && sel_lo) lo_d = sr_wdata;
        if (sr_wr && sel_hi) hi_d = sr_wdata;
    end

    // Reset opens the window completely.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '1;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    always_comb begin
        sr_rdata = '0;
        if (sel_lo)      sr_rdata = lo_q;
        else if (sel_hi) sr_rdata = hi_q;
    end

    assign lim_lo = lo_q;
    assign lim_hi = hi_q;

    assert_lo_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sr_wr) && $past(sr_num) == LO_NUM) |-> lim_lo == $past(sr_wdata));
    assert_hi_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sr_wr) && $past(sr_num) == HI_NUM) |-> lim_hi == $past(sr_wdata));
    assert_reset_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (lim_lo == '0 && lim_hi == '1));
endmodule

// File: rtl/sg_addr_gen.sv
module sg_addr_gen
    import sg_pkg::*;
#(
    parameter int unsigned          XLEN   = SG_XLEN,
    parameter int unsigned          IDX_W  = SG_IDX_W,
    parameter logic [IDX_W-1:0]     SP_IDX = 5'd1
) (
    input  logic             ls_valid,
    input  logic [IDX_W-1:0] ra_idx,
    input  logic [IDX_W-1:0] rb_idx,
    input  logic [XLEN-1:0]  op_a,
    input  logic [XLEN-1:0]  op_b,
    input  logic [XLEN-1:0]  imm,
    input  logic             imm_form,
    output logic [XLEN-1:0]  addr,
    output logic             check_en
);
    logic [XLEN-1:0] addend;
    logic            a_is_sp, b_is_sp;

    assign addend  = imm_form ? imm : op_b;
    assign addr    = op_a + addend;
    assign a_is_sp = (ra_idx == SP_IDX);
    // The B index only names a register in the register-register form.
    assign b_is_sp = !imm_form && (rb_idx == SP_IDX);
    assign check_en = ls_valid && (a_is_sp || b_is_sp);
endmodule

// File: rtl/sg_bound_cmp.sv
module sg_bound_cmp
    import sg_pkg::*;
#(
    parameter int unsigned XLEN = SG_XLEN
) (
    input  logic [XLEN-1:0] addr,
    input  logic [XLEN-1:0] lim_lo,
    input  logic [XLEN-1:0] lim_hi,
    output logic            outside
);
    logic below, above;
    // Unsigned compares; both limits are inside the window.
    assign below   = addr < lim_lo;
    assign above   = addr > lim_hi;
    assign outside = below || above;
endmodule

// File: rtl/stack_guard.sv
module stack_guard
    import sg_pkg::*;
#(
    parameter int unsigned XLEN    = SG_XLEN,
    parameter int unsigned IDX_W   = SG_IDX_W,
    parameter int unsigned SRN_W   = SG_SRN_W,
    parameter int unsigned CAUSE_W = SG_CAUSE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ls_valid,
    input  logic [IDX_W-1:0] ra_idx,
    input  logic [IDX_W-1:0] rb_idx,
    input  logic [XLEN-1:0]  op_a,
    input  logic [XLEN-1:0]  op_b,
    input  logic [XLEN-1:0]  imm,
    input  logic             imm_form,
    input  logic [SRN_W-1:0] sr_num,
    input  logic             sr_wr,
    input  logic [XLEN-1:0]  sr_wdata,
    output logic [XLEN-1:0]  sr_rdata,
    output logic [XLEN-1:0]  eff_addr,
    output logic             exc_pulse,
    output logic [XLEN-1:0]  exc_addr,
    output logic [XLEN-1:0]  exc_status
);
    localparam logic [XLEN-1:0] STATUS_VAL = XLEN'(SG_CAUSE_STACK);

    logic [XLEN-1:0] lim_lo, lim_hi;
    logic            check_en, outside, fault;
    sg_fault_t       st_d, st_q;

    sg_limit_regs #(.XLEN(XLEN), .SRN_W(SRN_W)) i_limits (
        .clk(clk), .rst_n(rst_n), .sr_num(sr_num), .sr_wr(sr_wr),
        .sr_wdata(sr_wdata), .sr_rdata(sr_rdata),
        .lim_lo(lim_lo), .lim_hi(lim_hi)
    );

    sg_addr_gen #(.XLEN(XLEN), .IDX_W(IDX_W)) i_addr (
        .ls_valid(ls_valid), .ra_idx(ra_idx), .rb_idx(rb_idx),
        .op_a(op_a), .op_b(op_b), .imm(imm), .imm_form(imm_form),
        .addr(eff_addr), .check_en(check_en)
    );

    sg_bound_cmp #(.XLEN(XLEN)) i_cmp (
        .addr(eff_addr), .lim_lo(lim_lo), .lim_hi(lim_hi), .outside(outside)
    );

    assign fault = check_en && outside;

    always_comb begin
        st_d     = st_q;
        st_d.exc = fault;
        if (fault) begin
            st_d.ear = eff_addr;
            st_d.esr = STATUS_VAL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign exc_pulse  = st_q.exc;
    assign exc_addr   = st_q.ear;
    assign exc_status = st_q.esr;

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ls_valid |=> !exc_pulse);
    assert_ear_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pulse |-> exc_addr == $past(eff_addr));
    assert_cause_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pulse |-> exc_status == 32'h7);
    assert_sp_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_valid && ra_idx != 5'd1 && (imm_form || rb_idx != 5'd1)) |=> !exc_pulse);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !exc_pulse) |-> ($stable(exc_addr) && $stable(exc_status)));
endmodule

// File: tb/test_stack_guard.sv
module test_stack_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ls_valid = 1'b0;
    logic [4:0]  ra_idx = '0, rb_idx = '0;
    logic [31:0] op_a = '0, op_b = '0, imm = '0;
    logic        imm_form = 1'b0;
    logic [13:0] sr_num = '0;
    logic        sr_wr = 1'b0;
    logic [31:0] sr_wdata = '0;
    logic [31:0] sr_rdata, eff_addr, exc_addr, exc_status;
    logic        exc_pulse;

    int unsigned vectors = 0, miscompares = 0;
    logic [31:0] m_lo = 32'h0, m_hi = 32'hFFFF_FFFF;
    logic        e_exc = 1'b0;
    logic [31:0] e_ear = '0, e_esr = '0;
    string       e_tag = "R8";

    always #10 clk = ~clk;

    stack_guard i_stack_guard (
        .clk(clk), .rst_n(rst_n), .ls_valid(ls_valid), .ra_idx(ra_idx),
        .rb_idx(rb_idx), .op_a(op_a), .op_b(op_b), .imm(imm),
        .imm_form(imm_form), .sr_num(sr_num), .sr_wr(sr_wr),
        .sr_wdata(sr_wdata), .sr_rdata(sr_rdata), .eff_addr(eff_addr),
        .exc_pulse(exc_pulse), .exc_addr(exc_addr), .exc_status(exc_status)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] f_addr(logic [31:0] a, logic [31:0] b,
                                           logic [31:0] i, logic form);
        return form ? a + i : a + b;
    endfunction

    function automatic logic f_fault(logic v, logic [4:0] ra, logic [4:0] rb, logic form,
                                     logic [31:0] ad, logic [31:0] lo, logic [31:0] hi);
        logic en;
        en = v && (ra == 5'd1 || (!form && rb == 5'd1));
        return en && (ad < lo || ad > hi);
    endfunction

    function automatic logic [31:0] f_read(logic [13:0] n);
        if (n == 14'h800) return m_lo;
        if (n == 14'h802) return m_hi;
        return 32'h0;
    endfunction

    // One cycle: check registered outputs of the previous cycle, drive, check comb outputs, predict.
    task automatic step(input logic v, input logic [4:0] ra, input logic [4:0] rb,
                        input logic [31:0] a, input logic [31:0] b, input logic [31:0] i,
                        input logic form, input logic wr, input logic [13:0] n,
                        input logic [31:0] wd, input string tag);
        logic [31:0] ad;
        @(negedge clk);
        chk({e_tag, " R5 exc_pulse"}, {31'b0, exc_pulse}, {31'b0, e_exc});
        chk({e_tag, " R5 R10 exc_addr"}, exc_addr, e_ear);
        chk({e_tag, " R6 R10 exc_status"}, exc_status, e_esr);
        ls_valid = v; ra_idx = ra; rb_idx = rb; op_a = a; op_b = b; imm = i;
        imm_form = form; sr_wr = wr; sr_num = n; sr_wdata = wd;
        #1;
        ad = f_addr(a, b, i, form);
        chk("R1 eff_addr", eff_addr, ad);
        chk("R7 sr_rdata", sr_rdata, f_read(n));
        e_exc = f_fault(v, ra, rb, form, ad, m_lo, m_hi);
        if (e_exc) begin
            e_ear = ad;
            e_esr = 32'h7;
        end
        e_tag = tag;
        if (wr && n == 14'h800) m_lo = wd;
        if (wr && n == 14'h802) m_hi = wd;
    endtask

    task automatic wr_lim(input logic [13:0] n, input logic [31:0] d);
        step(1'b0, 5'd0, 5'd0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1, n, d, "R7");
    endtask

    initial begin
        #(200000 * 20);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 exc_pulse", {31'b0, exc_pulse}, 32'h0);
        chk("R8 exc_addr", exc_addr, 32'h0);
        chk("R8 exc_status", exc_status, 32'h0);
        rst_n = 1'b1;
        sr_num = 14'h800; #1 chk("R8 low limit", sr_rdata, 32'h0);
        sr_num = 14'h802; #1 chk("R8 high limit", sr_rdata, 32'hFFFF_FFFF);
        // R8: open window, extreme addresses never fault
        step(1, 5'd1, 5'd0, 32'hFFFF_FFFF, 32'h0, 32'h0, 0, 0, 14'h802, 0, "R8");
        step(1, 5'd1, 5'd0, 32'h0, 32'h0, 32'h0, 1, 0, 14'h800, 0, "R8");
        wr_lim(14'h800, 32'h0000_1000);
        wr_lim(14'h802, 32'h0000_1FFF);
        // R4: limits inclusive
        step(1, 5'd1, 5'd3, 32'h0000_0F00, 32'h100, 32'h0, 0, 0, 14'h800, 0, "R4 at low");
        step(1, 5'd1, 5'd3, 32'h0000_1F00, 32'h0, 32'h0FF, 1, 0, 14'h802, 0, "R4 at high");
        step(1, 5'd1, 5'd3, 32'h0000_1000, 32'h0, 32'hFFFF_FFFF, 1, 0, 14'h0, 0, "R4 below");
        step(1, 5'd1, 5'd3, 32'h0000_2000, 32'h0, 32'h0, 0, 0, 14'h0, 0, "R4 above");
        step(0, 5'd2, 5'd3, 32'h0, 32'h0, 32'h0, 0, 0, 14'h0, 0, "R10 hold");
        // R3: B index enables only in register-register form
        step(1, 5'd2, 5'd1, 32'h0000_5000, 32'h4, 32'h0, 0, 0, 14'h0, 0, "R3 rb reg");
        step(1, 5'd2, 5'd1, 32'h0000_6000, 32'h0, 32'h8, 1, 0, 14'h0, 0, "R3 rb imm");
        // R2: neither index is 1
        step(1, 5'd7, 5'd9, 32'h0000_7000, 32'h0, 32'h0, 0, 0, 14'h0, 0, "R2 no sp");
        // R9: strobe low
        step(0, 5'd1, 5'd1, 32'h0000_8000, 32'h0, 32'h0, 0, 0, 14'h0, 0, "R9 idle");
        // R7: write in same cycle as access uses the old limit
        step(1, 5'd1, 5'd0, 32'h0000_2500, 32'h0, 32'h0, 0, 1, 14'h802, 32'h3000, "R7 old hi");
        step(1, 5'd1, 5'd0, 32'h0000_2500, 32'h0, 32'h0, 0, 0, 14'h802, 0, "R7 new hi");
        step(1, 5'd1, 5'd0, 32'h0000_3001, 32'h0, 32'h0, 0, 1, 14'h801, 32'h0, "R7 other num");
        // Constrained random
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] a, b, i;
            logic [4:0]  ra, rb;
            logic [13:0] n;
            logic        wr;
            if (k % 200 == 0) begin
                logic [31:0] base;
                base = $urandom;
                wr_lim(14'h800, base);
                wr_lim(14'h802, base + ($urandom % 32'h4000));
            end
            ra = ($urandom % 3 == 0) ? 5'd1 : 5'($urandom);
            rb = ($urandom % 3 == 0) ? 5'd1 : 5'($urandom);
            a  = m_lo + ($urandom % 32'h6000) - 32'h1000;
            b  = ($urandom % 32'h200);
            i  = ($urandom % 32'h200) - 32'h100;
            case ($urandom % 4)
                0: n = 14'h800;
                1: n = 14'h802;
                default: n = 14'($urandom);
            endcase
            wr = ($urandom % 50 == 0) && n != 14'h800 && n != 14'h802;
            step(($urandom % 5) != 0, ra, rb, a, b, i, 1'($urandom), wr, n,
                 $urandom, "R2 R3 R4 random");
        end
        step(0, 5'd0, 5'd0, 32'h0, 32'h0, 32'h0, 0, 0, 14'h0, 0, "R9");
        step(0, 5'd0, 5'd0, 32'h0, 32'h0, 32'h0, 0, 0, 14'h0, 0, "R9");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule